// File: doc/BRIEF.md
# Per-Flow Table Routing Stage

This block performs route computation for one router input port. Every packet carries a flow index in the low bits of its head flit. On acceptance, the head flit's index addresses a local route table. The entry gives four things: the output port, the virtual channel to use on the outgoing link, the index the next router will use, and a valid bit. The head flit leaves with its index field replaced by the next-hop index. Routes can be minimal or non-minimal, and each flow gets a static VC, because the table holds whatever the offline route planner loaded.

Body and tail flits do not consult the table. They follow the port and VC latched for their input VC by the packet's head, and the tail releases that latch. The table is written through a configuration port between workloads. A write wins over a flit presented in the same cycle, and each write is acknowledged one cycle later. The result of a lookup appears on registered outputs one clock after the flit is accepted. Virtual-channel arbitration, switch allocation and flit storage sit downstream and are not part of this block.

Top module: `flow_route_unit`

## Requirements
- R1: After reset, `out_valid`, `out_err` and `cfg_ack` are low, `in_ready` is high, and every table entry is invalid.
- R2: A configuration write stores `cfg_wdata` at `cfg_addr`, and `cfg_ack` is high for exactly the cycle after the write. The fields of `cfg_wdata` are: valid at the top bit, then port in the next PORT_W bits, then VC in the next VC_W bits, then next index in the low IDX_W bits. A later write to the same address replaces the route.
- R3: While `cfg_we` is high, `in_ready` is low and a flit presented that cycle is not accepted: `out_valid` stays low in the next cycle.
- R4: An accepted head flit (`in_kind` 2'b01) whose entry is valid produces, one cycle later, `out_valid` high, `out_port` and `out_vc` from the entry, and `out_err` low.
- R5: For a head flit, `out_data` equals `in_data` with its low IDX_W bits replaced by the entry's next index. All higher bits are unchanged.
- R6: Body (2'b00) and tail (2'b10) flits leave on the port and VC latched by the last head on the same input VC, with `out_data` equal to `in_data`.
- R7: A tail flit ends the packet. A later body flit on that input VC, with no new head, goes to the drop port with `out_err` high.
- R8: A head flit whose entry is invalid leaves with `out_err` high, `out_port` equal to DROP_PORT, `out_vc` zero and data unchanged. The body flits of that packet follow the drop port with `out_err` low.
- R9: Routes latched on different input VCs are independent, so interleaved packets keep their own routes.
- R10: A single-flit packet (`in_kind` 2'b11) is routed and rewritten like a head, and it leaves no route latched on its input VC.
- R11: `out_valid` is low in a cycle that follows one with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | IDX_W | Entry written |
| cfg_wdata | input | 1+PORT_W+VC_W+IDX_W | Entry contents {valid, port, vc, next} |
| cfg_ack | output | 1 | Write acknowledge, one cycle after `cfg_we` |
| in_valid | input | 1 | Flit present |
| in_ready | output | 1 | Flit can be taken this cycle |
| in_kind | input | 2 | 00 body, 01 head, 10 tail, 11 single |
| in_vc | input | $clog2(NUM_VC) | Input virtual channel of the flit |
| in_data | input | FLIT_W | Flit payload; flow index in low IDX_W bits of a head |
| out_valid | output | 1 | Routed flit present |
| out_port | output | PORT_W | Chosen output port |
| out_vc | output | VC_W | Chosen outgoing virtual channel |
| out_data | output | FLIT_W | Flit with rewritten index for heads |
| out_err | output | 1 | Route miss flag |

## Verification
The bench builds the unit with IDX_W=4, NUM_VC=2 and FLIT_W=16. With these values the top entry 15 and its wrap to next index 0 are cheap to reach, and a 16-bit flit leaves visible upper bits to confirm the rewrite leaves them alone. Two input VCs are enough to interleave packets and to show that a tail on one VC leaves the other's latched route intact. The default PORT_W=3 keeps the drop port 4 distinct from the four mesh directions.

// File: rtl/frt_pkg.sv
// Shared encodings for the per-flow table routing stage.
// Assumes flit kinds arrive as a 2-bit code: bit 0 = starts a packet, bit 1 = ends it.
package frt_pkg;
    typedef enum logic [1:0] {
        FK_BODY   = 2'b00,
        FK_HEAD   = 2'b01,
        FK_TAIL   = 2'b10,
        FK_SINGLE = 2'b11
    } flit_kind_e;

    localparam int unsigned PORT_NORTH = 0;
    localparam int unsigned PORT_EAST  = 1;
    localparam int unsigned PORT_SOUTH = 2;
    localparam int unsigned PORT_WEST  = 3;
    localparam int unsigned PORT_LOCAL = 4;
endpackage

// File: rtl/route_table.sv
// Route table: one entry per flow index, written by configuration, read combinationally.
// Assumes writes happen only between workloads; a read in the write cycle sees the old value.
module route_table #(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned PORT_W = 3,
    parameter int unsigned VC_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic              wr_valid,
    input  logic [PORT_W-1:0] wr_port,
    input  logic [VC_W-1:0]   wr_vc,
    input  logic [IDX_W-1:0]  wr_next,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic              rd_valid,
    output logic [PORT_W-1:0] rd_port,
    output logic [VC_W-1:0]   rd_vc,
    output logic [IDX_W-1:0]  rd_next
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic              valid_q [DEPTH];
    logic [PORT_W-1:0] port_q  [DEPTH];
    logic [VC_W-1:0]   vc_q    [DEPTH];
    logic [IDX_W-1:0]  next_q  [DEPTH];

    // Valid bits: cleared by reset, set or cleared by configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) valid_q[i] <= 1'b0;
        end else if (wr_en) begin
            valid_q[wr_addr] <= wr_valid;
        end
    end

    // Route payload: no reset needed, guarded by the valid bit.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            port_q[wr_addr] <= wr_port;
            vc_q[wr_addr]   <= wr_vc;
            next_q[wr_addr] <= wr_next;
        end
    end

    // Single-cycle read of the addressed entry.
    always_comb begin
        rd_valid = valid_q[rd_addr];
        rd_port  = port_q[rd_addr];
        rd_vc    = vc_q[rd_addr];
        rd_next  = next_q[rd_addr];
    end
endmodule

// File: rtl/vc_route_state.sv
// Per-input-VC route latch: holds the port and VC chosen by a packet's head until its tail.
// Assumes at most one update per cycle, for the VC named by upd_vc.
module vc_route_state #(
    parameter int unsigned NUM_VC = 4,
    parameter int unsigned PORT_W = 3,
    parameter int unsigned VC_W   = 2,
    localparam int unsigned SEL_W = $clog2(NUM_VC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [SEL_W-1:0]  upd_vc,
    input  logic              upd_open,
    input  logic              upd_close,
    input  logic [PORT_W-1:0] upd_port,
    input  logic [VC_W-1:0]   upd_outvc,
    input  logic [SEL_W-1:0]  rd_vc,
    output logic              rd_active,
    output logic [PORT_W-1:0] rd_port,
    output logic [VC_W-1:0]   rd_outvc
);
    logic [NUM_VC-1:0] active_w;
    logic [PORT_W-1:0] port_w  [NUM_VC];
    logic [VC_W-1:0]   outvc_w [NUM_VC];

    for (genvar g = 0; g < NUM_VC; g++) begin : g_vc
        logic              act_q;
        logic [PORT_W-1:0] port_q;
        logic [VC_W-1:0]   outvc_q;
        logic              hit;

        assign hit = upd_en && (upd_vc == SEL_W'(g));

        // Open on a head, release on a tail, for this VC only.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_q   <= 1'b0;
                port_q  <= '0;
                outvc_q <= '0;
            end else if (hit) begin
                if (upd_close) begin
                    act_q <= 1'b0;
                end else if (upd_open) begin
                    act_q   <= 1'b1;
                    port_q  <= upd_port;
                    outvc_q <= upd_outvc;
                end
            end
        end

        assign active_w[g] = act_q;
        assign port_w[g]   = port_q;
        assign outvc_w[g]  = outvc_q;
    end

    // Route read for the flit's input VC.
    always_comb begin
        rd_active = active_w[rd_vc];
        rd_port   = port_w[rd_vc];
        rd_outvc  = outvc_w[rd_vc];
    end

    // R7
    tail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_close) |=> !active_w[$past(upd_vc)]);
endmodule

// File: rtl/flow_route_unit.sv
// Route computation for one router input using a per-flow route table.
// Head flits look up their index, take port/VC from the entry and carry the
// next-hop index onward; body and tail flits reuse the route latched for their VC.
// Assumes FLIT_W > IDX_W, NUM_VC >= 2, and table writes only between workloads.
module flow_route_unit
    import frt_pkg::*;
#(
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned PORT_W    = 3,
    parameter int unsigned VC_W      = 2,
    parameter int unsigned NUM_VC    = 4,
    parameter int unsigned FLIT_W    = 32,
    parameter int unsigned DROP_PORT = PORT_LOCAL,
    localparam int unsigned SEL_W    = $clog2(NUM_VC),
    localparam int unsigned ENTRY_W  = 1 + PORT_W + VC_W + IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_addr,
    input  logic [ENTRY_W-1:0] cfg_wdata,
    output logic               cfg_ack,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [1:0]         in_kind,
    input  logic [SEL_W-1:0]   in_vc,
    input  logic [FLIT_W-1:0]  in_data,
    output logic               out_valid,
    output logic [PORT_W-1:0]  out_port,
    output logic [VC_W-1:0]    out_vc,
    output logic [FLIT_W-1:0]  out_data,
    output logic               out_err
);
    localparam int unsigned NEXT_LSB = 0;
    localparam int unsigned VC_LSB   = NEXT_LSB + IDX_W;
    localparam int unsigned PORT_LSB = VC_LSB + VC_W;
    localparam int unsigned VAL_BIT  = PORT_LSB + PORT_W;
    localparam logic [PORT_W-1:0] DROP = PORT_W'(DROP_PORT);

    flit_kind_e        kind;
    logic              accept;
    logic              tb_valid;
    logic [PORT_W-1:0] tb_port;
    logic [VC_W-1:0]   tb_vc;
    logic [IDX_W-1:0]  tb_next;
    logic              st_active;
    logic [PORT_W-1:0] st_port;
    logic [VC_W-1:0]   st_vc;
    logic [PORT_W-1:0] nxt_port;
    logic [VC_W-1:0]   nxt_vc;
    logic [FLIT_W-1:0] nxt_data;
    logic              nxt_err;

    assign kind     = flit_kind_e'(in_kind);
    assign in_ready = !cfg_we;
    assign accept   = in_valid && in_ready;

    route_table #(.IDX_W(IDX_W), .PORT_W(PORT_W), .VC_W(VC_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_valid (cfg_wdata[VAL_BIT]),
        .wr_port  (cfg_wdata[PORT_LSB +: PORT_W]),
        .wr_vc    (cfg_wdata[VC_LSB +: VC_W]),
        .wr_next  (cfg_wdata[NEXT_LSB +: IDX_W]),
        .rd_addr  (in_data[IDX_W-1:0]),
        .rd_valid (tb_valid),
        .rd_port  (tb_port),
        .rd_vc    (tb_vc),
        .rd_next  (tb_next)
    );

    vc_route_state #(.NUM_VC(NUM_VC), .PORT_W(PORT_W), .VC_W(VC_W)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (accept && (kind == FK_HEAD || kind == FK_TAIL)),
        .upd_vc    (in_vc),
        .upd_open  (kind == FK_HEAD),
        .upd_close (kind == FK_TAIL),
        .upd_port  (nxt_port),
        .upd_outvc (nxt_vc),
        .rd_vc     (in_vc),
        .rd_active (st_active),
        .rd_port   (st_port),
        .rd_outvc  (st_vc)
    );

    // Route choice: table for packet starts, latched route otherwise, drop port on a miss.
    always_comb begin
        nxt_data = in_data;
        nxt_err  = 1'b0;
        nxt_port = DROP;
        nxt_vc   = '0;
        if (kind[0]) begin
            if (tb_valid) begin
                nxt_port = tb_port;
                nxt_vc   = tb_vc;
                nxt_data = {in_data[FLIT_W-1:IDX_W], tb_next};
            end else begin
                nxt_err = 1'b1;
            end
        end else if (st_active) begin
            nxt_port = st_port;
            nxt_vc   = st_vc;
        end else begin
            nxt_err = 1'b1;
        end
    end

    // Output register: one cycle from acceptance to routed flit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_port  <= '0;
            out_vc    <= '0;
            out_data  <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_port <= nxt_port;
                out_vc   <= nxt_vc;
                out_data <= nxt_data;
                out_err  <= nxt_err;
            end else begin
                out_err  <= 1'b0;
            end
        end
    end

    // Configuration acknowledge, one cycle after the write.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_ack <= 1'b0;
        else        cfg_ack <= cfg_we;
    end

    // R3
    cfg_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && in_valid) |=> !out_valid);

    // R2
    ack_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ack |-> $past(cfg_we));

    // R8
    drop_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_port == DROP && out_vc == '0 && out_valid));

    // R4
    one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R11
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
endmodule

// File: tb/sim_flow_route_unit.sv
module sim_flow_route_unit;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W  = 4;
    localparam int PORT_W = 3;
    localparam int VC_W   = 2;
    localparam int NUM_VC = 2;
    localparam int FLIT_W = 16;
    localparam int ENTRY_W = 1 + PORT_W + VC_W + IDX_W;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_we = 1'b0;
    logic [IDX_W-1:0]   cfg_addr = '0;
    logic [ENTRY_W-1:0] cfg_wdata = '0;
    logic               cfg_ack;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [1:0]         in_kind = 2'b00;
    logic [0:0]         in_vc = '0;
    logic [FLIT_W-1:0]  in_data = '0;
    logic               out_valid;
    logic [PORT_W-1:0]  out_port;
    logic [VC_W-1:0]    out_vc;
    logic [FLIT_W-1:0]  out_data;
    logic               out_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flow_route_unit #(.IDX_W(IDX_W), .PORT_W(PORT_W), .VC_W(VC_W), .NUM_VC(NUM_VC),
                      .FLIT_W(FLIT_W), .DROP_PORT(4)) u0 (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input int addr, input bit v, input int port, input int vc, input int nxt);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = IDX_W'(addr);
        cfg_wdata = {v, PORT_W'(port), VC_W'(vc), IDX_W'(nxt)};
        @(posedge clk); #1;
        cfg_we = 1'b0;
        chk("R2 ack after write", int'(cfg_ack), 1);
        @(posedge clk); #1;
        chk("R2 ack one cycle", int'(cfg_ack), 0);
    endtask

    task automatic send(input logic [1:0] k, input int vc, input int d);
        @(negedge clk);
        in_valid = 1'b1; in_kind = k; in_vc = vc[0:0]; in_data = FLIT_W'(d);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic expect_out(input string tag, input int port, input int vc, input int d, input bit err);
        chk({tag, " valid"}, int'(out_valid), 1);
        chk({tag, " port"}, int'(out_port), port);
        chk({tag, " vc"}, int'(out_vc), vc);
        chk({tag, " data"}, int'(out_data), d);
        chk({tag, " err"}, int'(out_err), int'(err));
    endtask

    task automatic t_reset();
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 out_err", int'(out_err), 0);
        chk("R1 cfg_ack", int'(cfg_ack), 0);
        chk("R1 in_ready", int'(in_ready), 1);
        send(2'b01, 0, 'h3C05);
        expect_out("R1 empty table", 4, 0, 'h3C05, 1'b1);
        send(2'b10, 0, 'h0000);
    endtask

    task automatic t_example();
        cfg(1, 1'b1, 1, 2, 2);
        send(2'b01, 0, 'hABC1);
        expect_out("R4 R5 head", 1, 2, 'hABC2, 1'b0);
        send(2'b00, 0, 'h1234);
        expect_out("R6 body", 1, 2, 'h1234, 1'b0);
        send(2'b10, 0, 'h5678);
        expect_out("R6 tail", 1, 2, 'h5678, 1'b0);
        send(2'b00, 0, 'h9999);
        expect_out("R7 body after tail", 4, 0, 'h9999, 1'b1);
    endtask

    task automatic t_invalid();
        cfg(7, 1'b0, 2, 1, 3);
        send(2'b01, 1, 'h00F7);
        expect_out("R8 invalid head", 4, 0, 'h00F7, 1'b1);
        send(2'b00, 1, 'h4242);
        expect_out("R8 body to drop", 4, 0, 'h4242, 1'b0);
        send(2'b10, 1, 'h4343);
    endtask

    task automatic t_interleave();
        cfg(3, 1'b1, 3, 1, 9);
        cfg(15, 1'b1, 0, 3, 0);
        send(2'b01, 0, 'h7713);
        expect_out("R9 head vc0", 3, 1, 'h7719, 1'b0);
        send(2'b01, 1, 'hFEDF);
        expect_out("R5 R9 head vc1 wrap", 0, 3, 'hFED0, 1'b0);
        send(2'b00, 0, 'h0101);
        expect_out("R9 body vc0", 3, 1, 'h0101, 1'b0);
        send(2'b10, 1, 'h0202);
        expect_out("R9 tail vc1", 0, 3, 'h0202, 1'b0);
        send(2'b00, 0, 'h0303);
        expect_out("R9 vc0 kept after vc1 tail", 3, 1, 'h0303, 1'b0);
        send(2'b10, 0, 'h0404);
        expect_out("R9 tail vc0", 3, 1, 'h0404, 1'b0);
    endtask

    task automatic t_single();
        cfg(4, 1'b1, 2, 1, 6);
        send(2'b11, 0, 'h5554);
        expect_out("R10 single", 2, 1, 'h5556, 1'b0);
        send(2'b00, 0, 'h6666);
        expect_out("R10 no latch left", 4, 0, 'h6666, 1'b1);
    endtask

    task automatic t_priority();
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'd1; cfg_wdata = {1'b1, 3'd3, 2'd0, 4'd5};
        in_valid = 1'b1; in_kind = 2'b01; in_vc = 1'b0; in_data = 16'h2221;
        #1;
        chk("R3 in_ready low", int'(in_ready), 0);
        @(posedge clk); #1;
        cfg_we = 1'b0; in_valid = 1'b0;
        chk("R3 flit not taken", int'(out_valid), 0);
        chk("R2 ack with flit", int'(cfg_ack), 1);
        send(2'b11, 0, 'h2221);
        expect_out("R2 rewritten entry", 3, 0, 'h2225, 1'b0);
    endtask

    task automatic t_idle();
        @(posedge clk); #1;
        chk("R11 idle", int'(out_valid), 0);
        chk("R11 idle err", int'(out_err), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_example();
        t_invalid();
        t_interleave();
        t_single();
        t_priority();
        t_idle();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule